// File: doc/BRIEF.md
# Host Controller Command and Doorbell Register Slice

This block holds the command and status state that host software uses to steer a USB host controller's schedule engine. A command word carries two schedule-enable bits, a two-bit frame-list size code, a light (soft) reset request and an asynchronous-advance doorbell. A status word carries the async-advance flag, and an interrupt-enable word gates whether that flag raises an interrupt request. Software reaches all three words through a plain register port: a one-cycle write strobe with address and data, and a combinational read selected by its own address.

The doorbell is a handshake with the schedule engine. Software rings it. The engine later pulses `evict_done` once its cached schedule state is gone. The block then sets the status flag, clears the doorbell on the following clock, and raises `irq` only on the next interrupt-threshold tick. The block also turns the frame-list size into a mask on the frame index, which yields the current list index. All pins are plain control and status signals; no interface here moves a data stream, so there is no valid/ready handshake or back-pressure.

Top module: `hc_cmd_reg`

Register map (word address on `reg_addr`/`reg_rd_addr`):
- 0, command: bit 7 light reset (reads 1 while busy), bit 6 doorbell, bit 5 async schedule enable, bit 4 periodic schedule enable, bits 3:2 frame-list size.
- 1, status: bit 0 async-advance flag, write-1-to-clear.
- 2, interrupt enable: bit 0 async-advance interrupt enable.
- 3: reads 0.

## Requirements
- R1: The doorbell (command bit 6) is set only when software writes 1 to it. Writing 0 to bit 6 leaves the doorbell unchanged.
- R2: When `evict_done` is high on a clock edge while the doorbell is 1, that edge sets the status flag (status bit 0).
- R3: The doorbell returns to 0 on the clock edge after the one that set the status flag, and never before the flag is 1 (except through light reset).
- R4: `irq` rises only on a clock edge that samples `thresh_tick` high while the status flag and the interrupt enable (bit 0 of word 2) are both 1. It does not rise as soon as the flag is set.
- R5: After reset the command word reads 0: both schedule enables are 0 and the `async_sched_en` and `periodic_sched_en` outputs follow command bits 5 and 4.
- R6: The frame-list size field changes on a command write only while `prog_fls_cap` is 1. Otherwise it keeps its value.
- R7: The frame-list size resets to 00, which selects 1024 entries.
- R8: `list_index` equals `frame_index[11:2]` masked to 10 bits for size codes 00 and 11, to 9 bits for 01 and to 8 bits for 10.
- R9: Writing 1 to command bit 7 starts a light reset. Bit 7 and `light_reset_busy` read 1 for exactly 8 cycles. During that time the schedule enables and the doorbell are 0 and further command writes are ignored. The frame-list size, status flag and interrupt enable are kept.
- R10: A write of 1 to the doorbell while the async schedule enable is 0 does not set the doorbell, and it pulses `db_err` high for one cycle after that write.
- R11: Writing 1 to status bit 0 clears the flag. `irq` then falls on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | One-cycle register write strobe |
| reg_addr | input | 2 | Write word address |
| reg_wr_data | input | 32 | Write data |
| reg_rd_addr | input | 2 | Read word address |
| reg_rd_data | output | 32 | Combinational read data |
| prog_fls_cap | input | 1 | Capability: frame-list size is writable |
| evict_done | input | 1 | Engine pulse: cached schedule state evicted |
| thresh_tick | input | 1 | Interrupt-threshold boundary pulse |
| frame_index | input | 14 | Current frame index |
| async_sched_en | output | 1 | Process the asynchronous schedule |
| periodic_sched_en | output | 1 | Process the periodic schedule |
| list_index | output | 10 | Masked frame-list index |
| light_reset_busy | output | 1 | Light reset in progress |
| irq | output | 1 | Interrupt request |
| db_err | output | 1 | Pulse: doorbell rung with async schedule off |

## Verification
The doorbell handshake is driven through a directed sequence. It rings the doorbell with the async schedule both off and on, writes 0 over a set doorbell, pulses `evict_done` with the doorbell both clear and set, and holds `thresh_tick` low and then pulses it. This separates a flag set by eviction from one set by the write itself, and a deferred interrupt from an immediate one. The random phase mixes frame-list size writes, with the capability input randomly on or off, with random frame indices. A bench function computes the expected mask, so the run shows both whether a write was gated and whether the right bit width was kept. Light reset is exercised with a command write issued during the busy window and with non-default size and status state already in place, which shows what it clears and what it keeps.

// File: rtl/hc_cmd_pkg.sv
package hc_cmd_pkg;

  typedef enum logic [1:0] {
    FLS_1024 = 2'b00,
    FLS_512  = 2'b01,
    FLS_256  = 2'b10,
    FLS_RSVD = 2'b11
  } fls_e;

  localparam logic [1:0] ADDR_CMD = 2'd0;
  localparam logic [1:0] ADDR_STS = 2'd1;
  localparam logic [1:0] ADDR_IEN = 2'd2;

  localparam int CMD_LRST_BIT = 7;
  localparam int CMD_DB_BIT   = 6;
  localparam int CMD_ASE_BIT  = 5;
  localparam int CMD_PSE_BIT  = 4;
  localparam int CMD_FLS_LSB  = 2;
  localparam int STS_AA_BIT   = 0;
  localparam int IEN_AA_BIT   = 0;

endpackage

// File: rtl/hc_light_reset.sv
module hc_light_reset #(
  parameter int CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (start) begin
      cnt_q <= CW'(CYCLES);
    end
  end

  assign busy = (cnt_q != '0);

  AST_LR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(CYCLES)); // R9
  AST_LR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cnt_q) != '0 |-> cnt_q == $past(cnt_q) - 1'b1); // R9

endmodule

// File: rtl/hc_doorbell.sv
module hc_doorbell (
  input  logic clk,
  input  logic rst_n,
  input  logic ring_req,
  input  logic async_en,
  input  logic quiesce,
  input  logic evict_done,
  input  logic sts_w1c,
  input  logic ien,
  input  logic thresh_tick,
  output logic db,
  output logic flag,
  output logic irq,
  output logic db_err
);
  logic db_q, flag_q, irq_q, err_q, clr_pend_q;
  logic set_evt;

  assign set_evt = db_q && evict_done && !quiesce && !clr_pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      db_q       <= 1'b0;
      flag_q     <= 1'b0;
      irq_q      <= 1'b0;
      err_q      <= 1'b0;
      clr_pend_q <= 1'b0;
    end else begin
      err_q      <= ring_req && !async_en && !quiesce;
      clr_pend_q <= set_evt;

      if (quiesce)                     db_q <= 1'b0;
      else if (clr_pend_q)             db_q <= 1'b0;
      else if (ring_req && async_en)   db_q <= 1'b1;

      if (set_evt)      flag_q <= 1'b1;
      else if (sts_w1c) flag_q <= 1'b0;

      if (!(flag_q && ien)) irq_q <= 1'b0;
      else if (thresh_tick) irq_q <= 1'b1;
    end
  end

  assign db     = db_q;
  assign flag   = flag_q;
  assign irq    = irq_q;
  assign db_err = err_q;

  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(db_q && evict_done)); // R2
  AST_DB_CLR_AFTER_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(db_q) |-> ($past(flag_q) || $past(quiesce))); // R3
  AST_IRQ_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(thresh_tick)); // R4
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(flag_q && ien)); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> $past(ring_req && !async_en)); // R10
  AST_DB_SET_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(db_q) |-> $past(ring_req && async_en)); // R1

endmodule

// File: rtl/hc_frame_mask.sv
module hc_frame_mask #(
  parameter int FIDX_W  = 14,
  parameter int IDX_W   = 10,
  parameter int IDX_LSB = 2
) (
  input  logic [FIDX_W-1:0] frame_index,
  input  logic [1:0]        fls,
  output logic [IDX_W-1:0]  list_index
);
  import hc_cmd_pkg::*;

  localparam int WW = $clog2(IDX_W + 1);

  logic [WW-1:0] keep_w;

  always_comb begin
    unique case (fls_e'(fls))
      FLS_512: keep_w = WW'(IDX_W - 1);
      FLS_256: keep_w = WW'(IDX_W - 2);
      default: keep_w = WW'(IDX_W);
    endcase
  end

  for (genvar g = 0; g < IDX_W; g++) begin : g_bit
    assign list_index[g] = frame_index[IDX_LSB + g] && (WW'(g) < keep_w);
  end

endmodule

// File: rtl/hc_cmd_reg.sv
module hc_cmd_reg #(
  parameter int FIDX_W    = 14,
  parameter int IDX_W     = 10,
  parameter int IDX_LSB   = 2,
  parameter int LR_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wr_data,
  input  logic [1:0]        reg_rd_addr,
  output logic [31:0]       reg_rd_data,
  input  logic              prog_fls_cap,
  input  logic              evict_done,
  input  logic              thresh_tick,
  input  logic [FIDX_W-1:0] frame_index,
  output logic              async_sched_en,
  output logic              periodic_sched_en,
  output logic [IDX_W-1:0]  list_index,
  output logic              light_reset_busy,
  output logic              irq,
  output logic              db_err
);
  import hc_cmd_pkg::*;

  logic       ase_q, pse_q, ien_q;
  logic [1:0] fls_q;
  logic       lr_busy, lr_start, quiesce;
  logic       wr_cmd, wr_cmd_ok, wr_sts, wr_ien;
  logic       ring_req, db, flag;

  assign wr_cmd    = reg_wr_en && (reg_addr == ADDR_CMD);
  assign wr_sts    = reg_wr_en && (reg_addr == ADDR_STS);
  assign wr_ien    = reg_wr_en && (reg_addr == ADDR_IEN);
  assign wr_cmd_ok = wr_cmd && !lr_busy;
  assign lr_start  = wr_cmd_ok && reg_wr_data[CMD_LRST_BIT];
  assign quiesce   = lr_start || lr_busy;
  assign ring_req  = wr_cmd_ok && reg_wr_data[CMD_DB_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ase_q <= 1'b0;
      pse_q <= 1'b0;
      fls_q <= FLS_1024;
      ien_q <= 1'b0;
    end else begin
      if (quiesce) begin
        ase_q <= 1'b0;
        pse_q <= 1'b0;
      end else if (wr_cmd_ok) begin
        ase_q <= reg_wr_data[CMD_ASE_BIT];
        pse_q <= reg_wr_data[CMD_PSE_BIT];
      end
      if (wr_cmd_ok && prog_fls_cap)
        fls_q <= reg_wr_data[CMD_FLS_LSB +: 2];
      if (wr_ien)
        ien_q <= reg_wr_data[IEN_AA_BIT];
    end
  end

  hc_light_reset #(.CYCLES(LR_CYCLES)) u_lrst (
    .clk   (clk),
    .rst_n (rst_n),
    .start (lr_start),
    .busy  (lr_busy)
  );

  hc_doorbell u_db (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_req    (ring_req),
    .async_en    (ase_q),
    .quiesce     (quiesce),
    .evict_done  (evict_done),
    .sts_w1c     (wr_sts && reg_wr_data[STS_AA_BIT]),
    .ien         (ien_q),
    .thresh_tick (thresh_tick),
    .db          (db),
    .flag        (flag),
    .irq         (irq),
    .db_err      (db_err)
  );

  hc_frame_mask #(.FIDX_W(FIDX_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_mask (
    .frame_index (frame_index),
    .fls         (fls_q),
    .list_index  (list_index)
  );

  always_comb begin
    reg_rd_data = '0;
    unique case (reg_rd_addr)
      ADDR_CMD: begin
        reg_rd_data[CMD_LRST_BIT]       = lr_busy;
        reg_rd_data[CMD_DB_BIT]         = db;
        reg_rd_data[CMD_ASE_BIT]        = ase_q;
        reg_rd_data[CMD_PSE_BIT]        = pse_q;
        reg_rd_data[CMD_FLS_LSB +: 2]   = fls_q;
      end
      ADDR_STS: reg_rd_data[STS_AA_BIT] = flag;
      ADDR_IEN: reg_rd_data[IEN_AA_BIT] = ien_q;
      default:  reg_rd_data = '0;
    endcase
  end

  assign async_sched_en    = ase_q;
  assign periodic_sched_en = pse_q;
  assign light_reset_busy  = lr_busy;

  AST_FLS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!prog_fls_cap) |-> $stable(fls_q)); // R6
  AST_LR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    lr_busy |-> (!ase_q && !pse_q && !db)); // R9
  AST_LR_KEEP_FLS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lr_busy) |-> $stable(fls_q)); // R9

endmodule

// File: tb/hc_cmd_reg_tb.sv
module hc_cmd_reg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic [1:0]  reg_rd_addr = '0;
  logic [31:0] reg_rd_data;
  logic        prog_fls_cap = 1'b0;
  logic        evict_done = 1'b0;
  logic        thresh_tick = 1'b0;
  logic [13:0] frame_index = '0;
  logic        async_sched_en, periodic_sched_en, light_reset_busy, irq, db_err;
  logic [9:0]  list_index;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hc_cmd_reg u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .prog_fls_cap(prog_fls_cap), .evict_done(evict_done), .thresh_tick(thresh_tick),
    .frame_index(frame_index), .async_sched_en(async_sched_en),
    .periodic_sched_en(periodic_sched_en), .list_index(list_index),
    .light_reset_busy(light_reset_busy), .irq(irq), .db_err(db_err)
  );

  function automatic logic [9:0] exp_index(logic [13:0] fi, logic [1:0] fls);
    logic [9:0] m;
    case (fls)
      2'b01:   m = 10'h1FF;
      2'b10:   m = 10'h0FF;
      default: m = 10'h3FF;
    endcase
    return fi[11:2] & m;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  function automatic logic [31:0] rd(logic [1:0] a);
    reg_rd_addr = a;
    return 32'(0);
  endfunction

  task automatic rd_chk(string req, logic [1:0] a, logic [31:0] exp);
    reg_rd_addr = a;
    #1;
    check(req, reg_rd_data, exp);
  endtask

  task automatic pulse_evict();
    @(negedge clk); evict_done = 1'b1;
    @(negedge clk); evict_done = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); thresh_tick = 1'b1;
    @(negedge clk); thresh_tick = 1'b0;
  endtask

  initial begin
    #(10 * 150000);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [1:0] fls_m;
    int n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 R7 reset state
    rd_chk("R5 cmd reset", 2'd0, 32'h0);
    rd_chk("R5 sts reset", 2'd1, 32'h0);
    check("R5 async out", {31'b0, async_sched_en}, 0);
    frame_index = 14'h3FFC;
    #1 check("R7 default mask", {22'b0, list_index}, {22'b0, exp_index(14'h3FFC, 2'b00)});

    // R10 doorbell with async off
    wr(2'd0, 32'h40);
    check("R10 db_err pulse", {31'b0, db_err}, 1);
    rd_chk("R10 db not set", 2'd0, 32'h0);
    @(negedge clk);
    check("R10 db_err one cycle", {31'b0, db_err}, 0);

    // R5 enable schedules
    wr(2'd0, 32'h30);
    check("R5 async en", {31'b0, async_sched_en}, 1);
    check("R5 periodic en", {31'b0, periodic_sched_en}, 1);
    wr(2'd0, 32'h20);
    check("R5 periodic off", {31'b0, periodic_sched_en}, 0);

    // R2 eviction without doorbell does nothing
    pulse_evict();
    rd_chk("R2 no flag without db", 2'd1, 32'h0);

    // R1 ring and write 0 over it
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h60);
    rd_chk("R1 db set", 2'd0, 32'h60);
    check("R1 no err", {31'b0, db_err}, 0);
    wr(2'd0, 32'h20);
    rd_chk("R1 write0 no effect", 2'd0, 32'h60);

    // R2 R3 handshake
    pulse_evict();
    rd_chk("R2 flag set", 2'd1, 32'h1);
    rd_chk("R3 db still set", 2'd0, 32'h60);
    @(negedge clk);
    rd_chk("R3 db cleared", 2'd0, 32'h20);

    // R4 deferred interrupt
    repeat (4) @(negedge clk);
    check("R4 no irq before tick", {31'b0, irq}, 0);
    pulse_tick();
    check("R4 irq on tick", {31'b0, irq}, 1);

    // R11 W1C
    wr(2'd1, 32'h0);
    rd_chk("R11 write0 keeps flag", 2'd1, 32'h1);
    wr(2'd1, 32'h1);
    rd_chk("R11 flag cleared", 2'd1, 32'h0);
    @(negedge clk);
    check("R11 irq falls", {31'b0, irq}, 0);
    pulse_tick();
    check("R11 no irq after clear", {31'b0, irq}, 0);

    // R4 enable off blocks irq
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h60);
    pulse_evict();
    @(negedge clk);
    pulse_tick();
    check("R4 irq gated by enable", {31'b0, irq}, 0);
    wr(2'd1, 32'h1);

    // R6 R8 random frame size and index
    fls_m = 2'b00;
    for (int i = 0; i < 300; i++) begin
      logic [1:0] nf;
      nf = 2'($urandom_range(0, 3));
      prog_fls_cap = 1'($urandom_range(0, 1));
      wr(2'd0, 32'h20 | (32'(nf) << 2));
      if (prog_fls_cap) fls_m = nf;
      rd_chk("R6 fls gate", 2'd0, 32'h20 | (32'(fls_m) << 2));
      for (int j = 0; j < 3; j++) begin
        frame_index = 14'($urandom);
        #1 check("R8 list index", {22'b0, list_index}, {22'b0, exp_index(frame_index, fls_m)});
      end
    end
    prog_fls_cap = 1'b1;
    wr(2'd0, 32'h28);
    prog_fls_cap = 1'b0;
    frame_index = 14'h3FFF;
    #1 check("R8 256 entries", {22'b0, list_index}, 32'h0FF);

    // R9 light reset keeps fls and status
    wr(2'd0, 32'h60);
    pulse_evict();
    @(negedge clk);
    wr(2'd0, 32'hB0);
    check("R9 busy", {31'b0, light_reset_busy}, 1);
    rd_chk("R9 cmd during reset", 2'd0, 32'h88);
    wr(2'd0, 32'h30);
    rd_chk("R9 write ignored", 2'd0, 32'h88);
    n = 2;
    while (light_reset_busy && n < 50) begin
      @(negedge clk);
      n++;
    end
    check("R9 busy length", 32'(n), 32'd8);
    rd_chk("R9 after reset", 2'd0, 32'h08);
    rd_chk("R9 status kept", 2'd1, 32'h1);
    rd_chk("R9 ien kept", 2'd2, 32'h0);
    wr(2'd0, 32'h20);
    check("R9 writes resume", {31'b0, async_sched_en}, 1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule